// File: doc/BRIEF.md
# Limited-Pointer Sharer Directory Entry

This block keeps the sharer record for a single coherent memory line. It holds a small fixed set of node pointers instead of one presence bit per node. A home controller sends it one operation at a time: add a sharer, remove a sharer, clear the entry, or a write by a node. On a write, the block produces the set of nodes that must be invalidated. It sends them out one node per handshake in ascending node order, and then gives a completion pulse.

When every pointer slot is taken and another distinct node asks to share the line, the entry overflows. A run-time policy input decides how the overflow is handled. The first policy sets a broadcast flag, so a later write reaches every node. The second policy evicts one pointer in round-robin order and sends that displaced node an invalidation. The third policy turns the entry into a coarse vector with one bit per group of nodes. Node count, pointer count and group size are parameters.

Top module: `lpd_dir_entry`

## Requirements
- R1: After reset the entry is in pointer mode with every slot empty, `op_ready` is 1, and `inv_valid` and `inv_done` are 0.
- R2: An operation is accepted on a clock edge where `op_valid` and `op_ready` are both 1. `op_code` 0 is add. In pointer mode, an add of a node that is not yet present fills the lowest-numbered free slot. An add of a node that is already present changes nothing and does not count toward overflow.
- R3: `op_code` 1 is remove. In pointer mode it frees the slot that holds the node. In broadcast or coarse mode it has no effect on the entry.
- R4: `op_code` 2 is clear. It returns the entry to pointer mode with all slots empty, the broadcast flag off, the coarse vector zero and the round-robin index at 0. It emits no invalidations.
- R5: `op_code` 3 is write. The invalidation set is the entry's current sharers minus the writing node. After the write, the entry holds only the writer, in pointer mode, with the round-robin index at 0.
- R6: Invalidations are sent in ascending node order, one per cycle where `inv_valid` and `inv_ready` are both 1. `inv_node` stays stable while `inv_ready` is low. `op_ready` is 0 while a list is pending. `inv_done` is high for exactly one cycle with `inv_valid` low. That cycle follows the last handshake, or follows the accepting edge when the set is empty.
- R7: With `ovf_policy` 0 or 3 (broadcast), an overflowing add sets broadcast mode. Later adds do nothing, and a write invalidates every node except the writer.
- R8: With `ovf_policy` 1 (replacement), an overflowing add stores the new node in the slot at the round-robin index. The index starts at 0 and advances by one modulo the pointer count per replacement. The displaced node is sent as a single invalidation, followed by `inv_done`.
- R9: With `ovf_policy` 2 (coarse), an overflowing add sets group bit node/GROUP for every stored pointer and for the new node. Later adds set their group bit. A write invalidates every node of every set group except the writer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation request |
| op_ready | output | 1 | Entry can accept an operation |
| op_code | input | 2 | 0 add, 1 remove, 2 clear, 3 write |
| op_node | input | $clog2(NODES) | Node that the operation refers to |
| ovf_policy | input | 2 | Overflow policy: 0/3 broadcast, 1 replace, 2 coarse |
| inv_valid | output | 1 | An invalidation target is presented |
| inv_ready | input | 1 | Consumer takes the target |
| inv_node | output | $clog2(NODES) | Node to invalidate |
| inv_done | output | 1 | Pulse after the last target of a list |

## Verification
The embedded assertions check the handshake rules on every cycle. They cover: `inv_node` holding while stalled, `op_ready` staying low while a list is pending, `inv_done` being a single cycle that never overlaps `inv_valid`, no node occupying two slots, and the state that clear, write and imprecise-mode remove must leave behind. Only the bench scenarios can show that each invalidation set has the right contents. That includes duplicate adds not overflowing, the round-robin choice of victims, the group expansion in coarse mode and the broadcast reach. These depend on the history of operations and are compared against sets the bench computes.

// File: rtl/lpd_pkg.sv
package lpd_pkg;
   typedef enum logic [1:0] {
      OP_ADD    = 2'd0,
      OP_REMOVE = 2'd1,
      OP_CLEAR  = 2'd2,
      OP_WRITE  = 2'd3
   } lpd_op_e;

   typedef enum logic [1:0] {
      POL_BCAST   = 2'd0,
      POL_REPLACE = 2'd1,
      POL_COARSE  = 2'd2,
      POL_BCAST2  = 2'd3
   } lpd_pol_e;

   typedef enum logic [1:0] {
      MODE_PTR    = 2'd0,
      MODE_BCAST  = 2'd1,
      MODE_COARSE = 2'd2
   } lpd_mode_e;
endpackage

// File: rtl/lpd_slot_scan.sv
module lpd_slot_scan #(
   parameter int PTRS   = 4,
   parameter int NODE_W = 4,
   parameter int IDX_W  = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [PTRS-1:0]             slot_vld,
   input  logic [PTRS-1:0][NODE_W-1:0] slot_node,
   input  logic [NODE_W-1:0]           query,
   output logic                        hit,
   output logic [IDX_W-1:0]            hit_idx,
   output logic                        free_any,
   output logic [IDX_W-1:0]            free_idx
);
   logic [PTRS-1:0] hit_vec;

   genvar g;
   generate
      for (g = 0; g < PTRS; g++) begin : g_cmp
         assign hit_vec[g] = slot_vld[g] && (slot_node[g] == query);
      end
   endgenerate

   always_comb begin
      hit_idx  = '0;
      free_idx = '0;
      for (int i = PTRS - 1; i >= 0; i--) begin
         if (hit_vec[i])   hit_idx  = IDX_W'(i);
         if (!slot_vld[i]) free_idx = IDX_W'(i);
      end
   end

   assign hit      = |hit_vec;
   assign free_any = ~&slot_vld;

   AST_UNIQUE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec)) else $error("node held in two slots"); // R2
endmodule

// File: rtl/lpd_inv_stream.sv
module lpd_inv_stream #(
   parameter int NODES  = 16,
   parameter int NODE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [NODES-1:0]  load_map,
   output logic              busy,
   output logic              inv_valid,
   input  logic              inv_ready,
   output logic [NODE_W-1:0] inv_node,
   output logic              inv_done
);
   logic [NODES-1:0] pend_q;
   logic             busy_q;

   always_comb begin
      inv_node = '0;
      for (int n = NODES - 1; n >= 0; n--) begin
         if (pend_q[n]) inv_node = NODE_W'(n);
      end
   end

   assign busy      = busy_q;
   assign inv_valid = busy_q && (|pend_q);
   assign inv_done  = busy_q && (pend_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         busy_q <= 1'b0;
      end else if (!busy_q) begin
         if (load) begin
            pend_q <= load_map;
            busy_q <= 1'b1;
         end
      end else if (inv_done) begin
         busy_q <= 1'b0;
      end else if (inv_ready) begin
         pend_q[inv_node] <= 1'b0;
      end
   end

   AST_HOLD_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      inv_valid && !inv_ready |=> inv_valid && $stable(inv_node)) else $error("target moved"); // R6
   AST_DONE_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
      inv_done |-> !inv_valid) else $error("done with valid"); // R6
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      inv_done |=> !inv_done) else $error("done longer than a cycle"); // R6
endmodule

// File: rtl/lpd_dir_entry.sv
module lpd_dir_entry #(
   parameter int NODES = 16,
   parameter int PTRS  = 4,
   parameter int GROUP = 4,
   localparam int NODE_W = $clog2(NODES),
   localparam int IDX_W  = (PTRS > 1) ? $clog2(PTRS) : 1,
   localparam int GROUPS = (NODES + GROUP - 1) / GROUP,
   localparam int GRP_W  = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   output logic              op_ready,
   input  logic [1:0]        op_code,
   input  logic [NODE_W-1:0] op_node,
   input  logic [1:0]        ovf_policy,
   output logic              inv_valid,
   input  logic              inv_ready,
   output logic [NODE_W-1:0] inv_node,
   output logic              inv_done
);
   import lpd_pkg::*;

   generate
      if (NODES < 2)                   begin : g_bad_nodes $error("NODES must be at least 2"); end
      if (PTRS < 1 || PTRS >= NODES)   begin : g_bad_ptrs  $error("PTRS must be in 1..NODES-1"); end
      if (GROUP < 1 || GROUP > NODES)  begin : g_bad_grp   $error("GROUP must be in 1..NODES"); end
   endgenerate

   function automatic logic [GRP_W-1:0] grp_of(input logic [NODE_W-1:0] n);
      int q;
      q = int'(n) / GROUP;
      return q[GRP_W-1:0];
   endfunction

   lpd_mode_e                   mode_q, mode_d;
   logic [PTRS-1:0]             vld_q, vld_d;
   logic [PTRS-1:0][NODE_W-1:0] node_q, node_d;
   logic [GROUPS-1:0]           cvec_q, cvec_d;
   logic [IDX_W-1:0]            rr_q, rr_d;

   logic              hit, free_any, busy, accept, load;
   logic [IDX_W-1:0]  hit_idx, free_idx;
   logic [NODES-1:0]  load_map, sharer_map, coarse_map;
   lpd_op_e           op;
   lpd_pol_e          pol;

   assign op       = lpd_op_e'(op_code);
   assign pol      = lpd_pol_e'(ovf_policy);
   assign op_ready = !busy;
   assign accept   = op_valid && op_ready;

   lpd_slot_scan #(.PTRS(PTRS), .NODE_W(NODE_W), .IDX_W(IDX_W)) i_scan (
      .clk(clk), .rst_n(rst_n),
      .slot_vld(vld_q), .slot_node(node_q), .query(op_node),
      .hit(hit), .hit_idx(hit_idx), .free_any(free_any), .free_idx(free_idx)
   );

   genvar n;
   generate
      for (n = 0; n < NODES; n++) begin : g_expand
         assign coarse_map[n] = cvec_q[n / GROUP];
      end
   endgenerate

   always_comb begin
      sharer_map = '0;
      case (mode_q)
         MODE_BCAST:  sharer_map = '1;
         MODE_COARSE: sharer_map = coarse_map;
         default: begin
            for (int i = 0; i < PTRS; i++) begin
               if (vld_q[i]) sharer_map[node_q[i]] = 1'b1;
            end
         end
      endcase
   end

   always_comb begin
      mode_d   = mode_q;
      vld_d    = vld_q;
      node_d   = node_q;
      cvec_d   = cvec_q;
      rr_d     = rr_q;
      load     = 1'b0;
      load_map = '0;
      if (accept) begin
         case (op)
            OP_ADD: begin
               if (mode_q == MODE_COARSE) begin
                  cvec_d[grp_of(op_node)] = 1'b1;
               end else if (mode_q == MODE_PTR && !hit) begin
                  if (free_any) begin
                     vld_d[free_idx]  = 1'b1;
                     node_d[free_idx] = op_node;
                  end else begin
                     case (pol)
                        POL_REPLACE: begin
                           load_map[node_q[rr_q]] = 1'b1;
                           load         = 1'b1;
                           node_d[rr_q] = op_node;
                           rr_d = (rr_q == IDX_W'(PTRS - 1)) ? '0 : rr_q + 1'b1;
                        end
                        POL_COARSE: begin
                           mode_d = MODE_COARSE;
                           cvec_d = '0;
                           for (int i = 0; i < PTRS; i++) begin
                              cvec_d[grp_of(node_q[i])] = 1'b1;
                           end
                           cvec_d[grp_of(op_node)] = 1'b1;
                        end
                        default: mode_d = MODE_BCAST;
                     endcase
                  end
               end
            end
            OP_REMOVE: begin
               if (mode_q == MODE_PTR && hit) vld_d[hit_idx] = 1'b0;
            end
            OP_CLEAR: begin
               mode_d = MODE_PTR;
               vld_d  = '0;
               cvec_d = '0;
               rr_d   = '0;
            end
            default: begin
               load_map          = sharer_map;
               load_map[op_node] = 1'b0;
               load              = 1'b1;
               mode_d            = MODE_PTR;
               vld_d             = '0;
               vld_d[0]          = 1'b1;
               node_d[0]         = op_node;
               cvec_d            = '0;
               rr_d              = '0;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_PTR;
         vld_q  <= '0;
         node_q <= '0;
         cvec_q <= '0;
         rr_q   <= '0;
      end else begin
         mode_q <= mode_d;
         vld_q  <= vld_d;
         node_q <= node_d;
         cvec_q <= cvec_d;
         rr_q   <= rr_d;
      end
   end

   lpd_inv_stream #(.NODES(NODES), .NODE_W(NODE_W)) i_stream (
      .clk(clk), .rst_n(rst_n),
      .load(load), .load_map(load_map), .busy(busy),
      .inv_valid(inv_valid), .inv_ready(inv_ready),
      .inv_node(inv_node), .inv_done(inv_done)
   );

   AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      accept && op == OP_CLEAR |=> mode_q == MODE_PTR && vld_q == '0 && rr_q == '0) else $error("clear left state"); // R4
   AST_WRITE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
      accept && op == OP_WRITE |=> mode_q == MODE_PTR && $countones(vld_q) == 1 && node_q[0] == $past(op_node)) else $error("write owner"); // R5
   AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      inv_valid |-> !op_ready) else $error("ready while streaming"); // R6
   AST_REMOVE_IMPRECISE: assert property (@(posedge clk) disable iff (!rst_n)
      accept && op == OP_REMOVE && mode_q != MODE_PTR |=> $stable(mode_q) && $stable(cvec_q)) else $error("remove changed imprecise entry"); // R3
endmodule

// File: tb/test_lpd_dir_entry.sv
module test_lpd_dir_entry;
   localparam int NODES = 16;
   localparam int W     = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic op_valid = 1'b0;
   logic [1:0] op_code = 2'd0;
   logic [W-1:0] op_node = '0;
   logic [1:0] ovf_policy = 2'd0;
   logic inv_ready = 1'b1;
   logic op_ready, inv_valid, inv_done;
   logic [W-1:0] inv_node;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   lpd_dir_entry #(.NODES(NODES), .PTRS(4), .GROUP(4)) i_lpd_dir_entry (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
      .op_code(op_code), .op_node(op_node), .ovf_policy(ovf_policy),
      .inv_valid(inv_valid), .inv_ready(inv_ready), .inv_node(inv_node), .inv_done(inv_done)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic do_op(input logic [1:0] code, input int node, input logic [1:0] pol);
      @(negedge clk);
      while (!op_ready) @(negedge clk);
      op_code    = code;
      op_node    = W'(node);
      ovf_policy = pol;
      op_valid   = 1'b1;
      @(posedge clk);
      #1 op_valid = 1'b0;
   endtask

   task automatic quiet(input string req);
      @(negedge clk);
      chk(!inv_valid && !inv_done && op_ready, req, "no stream after op",
          {inv_valid, inv_done, op_ready}, 3'b001);
   endtask

   task automatic collect(input logic [NODES-1:0] exp, input bit stall, input string req);
      logic [NODES-1:0] got = '0;
      int last = -1;
      bit order_ok = 1'b1;
      bit seen_done = 1'b0;
      inv_ready = 1'b1;
      for (int k = 0; k < 200 && !seen_done; k++) begin
         @(negedge clk);
         if (inv_done) seen_done = 1'b1;
         else begin
            if (inv_valid && inv_ready) begin
               if (int'(inv_node) <= last) order_ok = 1'b0;
               last = int'(inv_node);
               got[inv_node] = 1'b1;
            end
            if (stall) inv_ready = ~inv_ready;
         end
      end
      inv_ready = 1'b1;
      chk(seen_done, req, "done pulse seen", 32'(seen_done), 1);
      chk(got == exp, req, "invalidation set", 32'(got), 32'(exp));
      chk(order_ok, req, "ascending order", 32'(order_ok), 1);
      @(negedge clk);
      chk(!inv_done && op_ready, "R6", "done one cycle, ready back",
          {inv_done, op_ready}, 2'b01);
   endtask

   function automatic logic [NODES-1:0] bits(input int a, input int b, input int c, input int d);
      logic [NODES-1:0] m = '0;
      if (a >= 0) m[a] = 1'b1;
      if (b >= 0) m[b] = 1'b1;
      if (c >= 0) m[c] = 1'b1;
      if (d >= 0) m[d] = 1'b1;
      return m;
   endfunction

   task automatic t_reset();
      @(negedge clk);
      chk(op_ready && !inv_valid && !inv_done, "R1", "reset outputs",
          {op_ready, inv_valid, inv_done}, 3'b100);
      do_op(2'd3, 2, 2'd0);
      collect('0, 1'b0, "R1");
   endtask

   task automatic t_pointer();
      do_op(2'd2, 0, 2'd0); quiet("R4");
      do_op(2'd0, 3, 2'd0); quiet("R2");
      do_op(2'd0, 5, 2'd0); quiet("R2");
      do_op(2'd0, 9, 2'd0); quiet("R2");
      do_op(2'd0, 5, 2'd0); quiet("R2");
      do_op(2'd3, 5, 2'd0);
      collect(bits(3, 9, -1, -1), 1'b1, "R5");
   endtask

   task automatic t_dup_no_overflow();
      do_op(2'd2, 0, 2'd0);
      for (int i = 1; i <= 4; i++) do_op(2'd0, i, 2'd0);
      do_op(2'd0, 2, 2'd0); quiet("R2");
      do_op(2'd3, 0, 2'd0);
      collect(bits(1, 2, 3, 4), 1'b0, "R2");
      do_op(2'd3, 7, 2'd0);
      collect(bits(0, -1, -1, -1), 1'b0, "R5");
   endtask

   task automatic t_remove();
      do_op(2'd2, 0, 2'd0);
      do_op(2'd0, 2, 2'd0);
      do_op(2'd0, 6, 2'd0);
      do_op(2'd1, 6, 2'd0); quiet("R3");
      do_op(2'd1, 11, 2'd0);
      do_op(2'd3, 15, 2'd0);
      collect(bits(2, -1, -1, -1), 1'b0, "R3");
   endtask

   task automatic t_broadcast();
      logic [NODES-1:0] all = '1;
      do_op(2'd2, 0, 2'd0);
      for (int i = 1; i <= 5; i++) do_op(2'd0, i, 2'd0);
      do_op(2'd1, 1, 2'd0);
      all[3] = 1'b0;
      do_op(2'd3, 3, 2'd0);
      collect(all, 1'b1, "R7");
      do_op(2'd3, 8, 2'd3);
      collect(bits(3, -1, -1, -1), 1'b0, "R7");
      do_op(2'd2, 0, 2'd3);
      for (int i = 1; i <= 5; i++) do_op(2'd0, i, 2'd3);
      do_op(2'd2, 0, 2'd0);
      do_op(2'd3, 0, 2'd0);
      collect('0, 1'b0, "R4");
   endtask

   task automatic t_replace();
      do_op(2'd2, 0, 2'd1);
      for (int i = 1; i <= 4; i++) do_op(2'd0, i, 2'd1);
      do_op(2'd0, 5, 2'd1);
      collect(bits(1, -1, -1, -1), 1'b0, "R8");
      do_op(2'd0, 6, 2'd1);
      collect(bits(2, -1, -1, -1), 1'b1, "R8");
      do_op(2'd3, 9, 2'd1);
      collect(bits(3, 4, 5, 6), 1'b0, "R8");
   endtask

   task automatic t_coarse();
      logic [NODES-1:0] e = 16'hF0FF;
      do_op(2'd2, 0, 2'd2);
      do_op(2'd0, 0, 2'd2);
      do_op(2'd0, 5, 2'd2);
      do_op(2'd0, 6, 2'd2);
      do_op(2'd0, 13, 2'd2);
      do_op(2'd0, 14, 2'd2); quiet("R9");
      do_op(2'd1, 0, 2'd2);
      e[5] = 1'b0;
      do_op(2'd3, 5, 2'd2);
      collect(e, 1'b1, "R9");
      do_op(2'd2, 0, 2'd2);
      for (int i = 0; i <= 4; i++) do_op(2'd0, i, 2'd2);
      do_op(2'd0, 9, 2'd2);
      do_op(2'd3, 0, 2'd2);
      collect(16'h0FFE, 1'b0, "R9");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL R6 watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_pointer();
      t_dup_no_overflow();
      t_remove();
      t_broadcast();
      t_replace();
      t_coarse();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule